// File: doc/BRIEF.md
# CPU Program Bank Address Mapper

This block sits between a CPU's 16-bit address bus and the memories behind it. It splits the CPU space into eight 8 KiB windows. Each window holds a bank number and a memory-kind tag. An access address is turned into a physical byte address: the bank number of the selected window, followed by the 13-bit offset. The block also drives a one-hot select that tells the system whether the access goes to program ROM, work RAM, disk RAM or mapper space.

A cartridge mapper controller loads the windows through a single-cycle write port. It can load one 8K window, a 16K pair, or the upper 32K half. The upper half takes either one base value or four independent values. A raw load sets a window's bank and tag without any size check. Every ROM bank number is reduced modulo the ROM size, given in 8K units, before it is stored. Loads therefore never point past the end of the ROM.

Top module: `cpu_bank_mapper`

## Requirements
- R1: The window index is cpu_addr[15:13]. phys_addr equals that window's stored bank number, concatenated above cpu_addr[12:0], and follows cpu_addr combinationally.
- R2: While rst_n is low, on each clock edge window i takes bank (i mod rom_banks) and the ROM tag 0x00.
- R3: wr_op 0 (8K ROM load) stores wr_banks[7:0] mod rom_banks into window wr_win and sets its tag to ROM. No other window changes.
- R4: wr_op 1 (16K load) with base n stores (2n mod rom_banks) into window wr_win and (2n+1 mod rom_banks) into window wr_win+1. The window index wraps from 7 to 0. Both windows get the ROM tag.
- R5: wr_op 2 (32K load) with base n stores (4n+k mod rom_banks) into window 4+k, for k = 0..3, each with the ROM tag.
- R6: wr_op 3 (32K four-value load) stores lane k, wr_banks[8k+7:8k], reduced mod rom_banks, into window 4+k, each with the ROM tag.
- R7: wr_op 4 (raw load) stores wr_banks[7:0] unreduced and the tag wr_kind into window wr_win.
- R8: Tag encoding is ROM 0x00, work RAM 0xFF, disk RAM 0x01, mapper 0x80. mem_sel is one-hot: bit0 ROM, bit1 work RAM, bit2 disk RAM, bit3 mapper. Any other tag value selects mapper space.
- R9: A write takes effect at the clock edge that samples wr_en high. Before that edge, the output still shows the old mapping. With wr_en low, the mapping does not change.
- R10: wr_op values 5, 6 and 7 leave every window unchanged.
- R11: A rom_banks value of 0 is treated as 1, so every wrapped bank becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_banks | input | 8 | ROM size in 8K units |
| wr_en | input | 1 | Bank write strobe |
| wr_op | input | 3 | Load kind (0 8K, 1 16K, 2 32K, 3 32K four-value, 4 raw) |
| wr_win | input | 3 | Target window for 8K, 16K and raw loads |
| wr_banks | input | 32 | Four 8-bit bank lanes; lane 0 is the base value |
| wr_kind | input | 8 | Tag for raw loads |
| cpu_addr | input | 16 | CPU access address |
| phys_addr | output | 21 | Physical byte address |
| mem_kind | output | 8 | Tag of the addressed window |
| mem_sel | output | 4 | One-hot target select |

## Verification
The bench uses a ROM size that is not a power of two, so any shortcut that masks bits instead of taking a remainder gives wrong banks after reset and after every ganged load. A 16K load aimed at window 7 checks that the partner window wraps to window 0; a design that did not wrap would write a nonexistent window or leave window 0 stale. A four-value load uses a lane value far above the ROM size, and a raw load uses a bank above it; one checks that the remainder is applied, the other that it is not. Unknown tags, reserved opcodes, a write with the strobe low, and a zero ROM size each come with a check, which catches designs that decode loosely, write without the strobe, or divide by zero.

// File: rtl/cpu_bank_pkg.sv
package cpu_bank_pkg;

   typedef enum logic [7:0] {
      KIND_ROM    = 8'h00,
      KIND_DRAM   = 8'h01,
      KIND_MAPPER = 8'h80,
      KIND_RAM    = 8'hFF
   } mem_kind_e;

   typedef enum logic [2:0] {
      OP_ROM8   = 3'd0,
      OP_ROM16  = 3'd1,
      OP_ROM32  = 3'd2,
      OP_ROM32Q = 3'd3,
      OP_RAW    = 3'd4
   } load_op_e;

   localparam int SEL_ROM = 0;
   localparam int SEL_RAM = 1;
   localparam int SEL_DRAM = 2;
   localparam int SEL_MAP = 3;
   localparam int SEL_W = 4;
   localparam int LANES = 4;

endpackage

// File: rtl/cpu_bank_expand.sv
module cpu_bank_expand
   import cpu_bank_pkg::*;
#(
   parameter int WIN_BITS = 3,
   parameter int BANK_W   = 8,
   localparam int NUM_WIN = 1 << WIN_BITS,
   localparam int REQ_W   = BANK_W + 2
) (
   input  logic                               wr_en,
   input  logic [2:0]                         wr_op,
   input  logic [WIN_BITS-1:0]                wr_win,
   input  logic [LANES*BANK_W-1:0]            wr_banks,
   input  logic [7:0]                         wr_kind,
   output logic [NUM_WIN-1:0]                 win_we,
   output logic [NUM_WIN-1:0][REQ_W-1:0]      win_req,
   output logic [NUM_WIN-1:0]                 win_wrap,
   output logic [NUM_WIN-1:0][7:0]            win_kind
);
   localparam int HI_BASE = NUM_WIN - LANES;

   logic [REQ_W-1:0] base_n;
   assign base_n = REQ_W'(wr_banks[BANK_W-1:0]);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam bit IN_HI = (i >= HI_BASE);
      localparam int LANE  = IN_HI ? (i - HI_BASE) : 0;
      logic [WIN_BITS-1:0] rel;
      logic [REQ_W-1:0]    lane_val;

      assign rel      = WIN_BITS'(i) - wr_win;
      assign lane_val = REQ_W'(wr_banks[LANE*BANK_W +: BANK_W]);

      always_comb begin
         win_we[i]   = 1'b0;
         win_req[i]  = base_n;
         win_wrap[i] = 1'b1;
         win_kind[i] = KIND_ROM;
         case (wr_op)
            OP_ROM8: begin
               win_we[i] = (rel == '0);
            end
            OP_ROM16: begin
               win_we[i]  = (rel <= WIN_BITS'(1));
               win_req[i] = (base_n << 1) | REQ_W'(rel[0]);
            end
            OP_ROM32: begin
               win_we[i]  = IN_HI;
               win_req[i] = (base_n << 2) | REQ_W'(LANE);
            end
            OP_ROM32Q: begin
               win_we[i]  = IN_HI;
               win_req[i] = lane_val;
            end
            OP_RAW: begin
               win_we[i]   = (rel == '0);
               win_wrap[i] = 1'b0;
               win_kind[i] = wr_kind;
            end
            default: win_we[i] = 1'b0;
         endcase
         win_we[i] = win_we[i] & wr_en;
      end
   end
endmodule

// File: rtl/cpu_bank_wrap.sv
module cpu_bank_wrap #(
   parameter int BANK_W = 8,
   localparam int REQ_W = BANK_W + 2
) (
   input  logic [REQ_W-1:0]  req,
   input  logic [BANK_W-1:0] size,
   input  logic              wrap,
   output logic [BANK_W-1:0] bank
);
   logic [REQ_W-1:0] divisor;
   logic [REQ_W-1:0] rem;

   assign divisor = (size == '0) ? REQ_W'(1) : REQ_W'(size);
   assign rem     = req % divisor;
   assign bank    = wrap ? rem[BANK_W-1:0] : req[BANK_W-1:0];
endmodule

// File: rtl/cpu_bank_translate.sv
module cpu_bank_translate
   import cpu_bank_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int WIN_BITS = 3,
   parameter int BANK_W   = 8,
   localparam int NUM_WIN = 1 << WIN_BITS,
   localparam int OFF_W   = ADDR_W - WIN_BITS
) (
   input  logic [ADDR_W-1:0]               cpu_addr,
   input  logic [NUM_WIN-1:0][BANK_W-1:0]  banks,
   input  logic [NUM_WIN-1:0][7:0]         kinds,
   output logic [BANK_W+OFF_W-1:0]         phys_addr,
   output logic [7:0]                      mem_kind,
   output logic [SEL_W-1:0]                mem_sel
);
   logic [WIN_BITS-1:0] win;
   assign win       = cpu_addr[ADDR_W-1 -: WIN_BITS];
   assign phys_addr = {banks[win], cpu_addr[OFF_W-1:0]};
   assign mem_kind  = kinds[win];

   always_comb begin
      mem_sel = '0;
      case (mem_kind)
         KIND_ROM:  mem_sel[SEL_ROM]  = 1'b1;
         KIND_RAM:  mem_sel[SEL_RAM]  = 1'b1;
         KIND_DRAM: mem_sel[SEL_DRAM] = 1'b1;
         default:   mem_sel[SEL_MAP]  = 1'b1;
      endcase
   end
endmodule

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper
   import cpu_bank_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int WIN_BITS = 3,
   parameter int BANK_W   = 8,
   localparam int NUM_WIN = 1 << WIN_BITS,
   localparam int OFF_W   = ADDR_W - WIN_BITS,
   localparam int REQ_W   = BANK_W + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [BANK_W-1:0]          rom_banks,
   input  logic                       wr_en,
   input  logic [2:0]                 wr_op,
   input  logic [WIN_BITS-1:0]        wr_win,
   input  logic [LANES*BANK_W-1:0]    wr_banks,
   input  logic [7:0]                 wr_kind,
   input  logic [ADDR_W-1:0]          cpu_addr,
   output logic [BANK_W+OFF_W-1:0]    phys_addr,
   output logic [7:0]                 mem_kind,
   output logic [SEL_W-1:0]           mem_sel
);
   if (WIN_BITS < 2) begin : g_bad_win
      $error("WIN_BITS must be at least 2 for the 32K group");
   end
   if (BANK_W < WIN_BITS) begin : g_bad_bank
      $error("BANK_W must cover the reset window numbers");
   end
   if (OFF_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed WIN_BITS");
   end

   logic [NUM_WIN-1:0]              win_we;
   logic [NUM_WIN-1:0][REQ_W-1:0]   win_req;
   logic [NUM_WIN-1:0]              win_wrap;
   logic [NUM_WIN-1:0][7:0]         win_kind;
   logic [NUM_WIN-1:0][BANK_W-1:0]  bank_q;
   logic [NUM_WIN-1:0][7:0]         kind_q;

   cpu_bank_expand #(.WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) u_expand (
      .wr_en    (wr_en),
      .wr_op    (wr_op),
      .wr_win   (wr_win),
      .wr_banks (wr_banks),
      .wr_kind  (wr_kind),
      .win_we   (win_we),
      .win_req  (win_req),
      .win_wrap (win_wrap),
      .win_kind (win_kind)
   );

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_slot
      logic [REQ_W-1:0]  req_mux;
      logic              wrap_mux;
      logic [BANK_W-1:0] bank_d;

      assign req_mux  = rst_n ? win_req[i] : REQ_W'(i);
      assign wrap_mux = rst_n ? win_wrap[i] : 1'b1;

      cpu_bank_wrap #(.BANK_W(BANK_W)) u_wrap (
         .req  (req_mux),
         .size (rom_banks),
         .wrap (wrap_mux),
         .bank (bank_d)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_q[i] <= bank_d;
            kind_q[i] <= KIND_ROM;
         end else if (win_we[i]) begin
            bank_q[i] <= bank_d;
            kind_q[i] <= win_kind[i];
         end
      end
   end

   cpu_bank_translate #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) u_xlate (
      .cpu_addr  (cpu_addr),
      .banks     (bank_q),
      .kinds     (kind_q),
      .phys_addr (phys_addr),
      .mem_kind  (mem_kind),
      .mem_sel   (mem_sel)
   );
endmodule

// File: rtl/cpu_bank_mapper_chk.sv
module cpu_bank_mapper_chk
   import cpu_bank_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int WIN_BITS = 3,
   parameter int BANK_W   = 8,
   localparam int NUM_WIN = 1 << WIN_BITS,
   localparam int OFF_W   = ADDR_W - WIN_BITS
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [BANK_W-1:0]          rom_banks,
   input logic                       wr_en,
   input logic [2:0]                 wr_op,
   input logic [WIN_BITS-1:0]        wr_win,
   input logic [LANES*BANK_W-1:0]    wr_banks,
   input logic [7:0]                 wr_kind,
   input logic [ADDR_W-1:0]          cpu_addr,
   input logic [BANK_W+OFF_W-1:0]    phys_addr,
   input logic [SEL_W-1:0]           mem_sel,
   input logic [NUM_WIN-1:0][BANK_W-1:0] bank_q,
   input logic [NUM_WIN-1:0][7:0]        kind_q
);
   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mem_sel) == 1);

   assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

   assert_rom8_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == OP_ROM8 && rom_banks != '0)
      |=> (bank_q[$past(wr_win)] < $past(rom_banks)) && (kind_q[$past(wr_win)] == KIND_ROM));

   assert_raw_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == OP_RAW)
      |=> (kind_q[$past(wr_win)] == $past(wr_kind))
          && (bank_q[$past(wr_win)] == $past(wr_banks[BANK_W-1:0])));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bank_q) && $stable(kind_q));

   assert_reserved_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op > OP_RAW) |=> $stable(bank_q) && $stable(kind_q));
endmodule

bind cpu_bank_mapper cpu_bank_mapper_chk #(
   .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rom_banks (rom_banks),
   .wr_en     (wr_en),
   .wr_op     (wr_op),
   .wr_win    (wr_win),
   .wr_banks  (wr_banks),
   .wr_kind   (wr_kind),
   .cpu_addr  (cpu_addr),
   .phys_addr (phys_addr),
   .mem_sel   (mem_sel),
   .bank_q    (bank_q),
   .kind_q    (kind_q)
);

// File: tb/test_cpu_bank_mapper.sv
module test_cpu_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rom_banks = 8'd6;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_op = '0;
   logic [2:0]  wr_win = '0;
   logic [31:0] wr_banks = '0;
   logic [7:0]  wr_kind = '0;
   logic [15:0] cpu_addr = '0;
   logic [20:0] phys_addr;
   logic [7:0]  mem_kind;
   logic [3:0]  mem_sel;

   int n_checks = 0;
   int n_fail = 0;
   logic [7:0] m_bank [8];
   logic [7:0] m_kind [8];

   always #10 clk = ~clk;

   cpu_bank_mapper i_cpu_bank_mapper (
      .clk(clk), .rst_n(rst_n), .rom_banks(rom_banks), .wr_en(wr_en),
      .wr_op(wr_op), .wr_win(wr_win), .wr_banks(wr_banks), .wr_kind(wr_kind),
      .cpu_addr(cpu_addr), .phys_addr(phys_addr), .mem_kind(mem_kind), .mem_sel(mem_sel)
   );

   function automatic logic [7:0] wrapb(int req, int size);
      int d = (size == 0) ? 1 : size;
      return 8'(req % d);
   endfunction

   function automatic logic [3:0] sel_of(logic [7:0] k);
      case (k)
         8'h00: return 4'b0001;
         8'hFF: return 4'b0010;
         8'h01: return 4'b0100;
         default: return 4'b1000;
      endcase
   endfunction

   task automatic check_win(int w, logic [12:0] off, string req);
      logic [20:0] exp_pa;
      cpu_addr = {3'(w), off};
      #1;
      exp_pa = {m_bank[w], off};
      n_checks++;
      if (phys_addr !== exp_pa || mem_sel !== sel_of(m_kind[w]) || mem_kind !== m_kind[w]) begin
         n_fail++;
         $display("FAIL %s window %0d: got pa=%h kind=%h sel=%b expected pa=%h kind=%h sel=%b",
                  req, w, phys_addr, mem_kind, mem_sel, exp_pa, m_kind[w], sel_of(m_kind[w]));
      end
   endtask

   task automatic check_all(string req);
      for (int w = 0; w < 8; w++) check_win(w, 13'(w * 997 + 5), req);
   endtask

   task automatic do_write(logic [2:0] op, logic [2:0] win, logic [31:0] banks, logic [7:0] kind);
      @(negedge clk);
      wr_en = 1'b1; wr_op = op; wr_win = win; wr_banks = banks; wr_kind = kind;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset_R2;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin m_bank[i] = wrapb(i, 6); m_kind[i] = 8'h00; end
      check_all("R2");
      check_win(3, 13'h1FFF, "R1");
      check_win(6, 13'h0000, "R1");
   endtask

   task automatic t_rom8_R3;
      do_write(3'd0, 3'd3, 32'd13, 8'h55);
      m_bank[3] = wrapb(13, 6);
      check_all("R3");
   endtask

   task automatic t_timing_R9;
      @(negedge clk);
      wr_en = 1'b1; wr_op = 3'd0; wr_win = 3'd2; wr_banks = 32'd4;
      check_win(2, 13'h0123, "R9 before edge");
      @(negedge clk);
      wr_en = 1'b0;
      m_bank[2] = 8'd4;
      check_win(2, 13'h0123, "R9 after edge");
      @(negedge clk);
      wr_op = 3'd0; wr_win = 3'd2; wr_banks = 32'd5;
      @(negedge clk);
      check_all("R9 strobe low");
   endtask

   task automatic t_rom16_R4;
      do_write(3'd1, 3'd7, 32'd4, 8'h00);
      m_bank[7] = wrapb(8, 6);
      m_bank[0] = wrapb(9, 6);
      check_all("R4");
   endtask

   task automatic t_rom32_R5;
      do_write(3'd2, 3'd0, 32'd2, 8'h00);
      for (int k = 0; k < 4; k++) m_bank[4 + k] = wrapb(8 + k, 6);
      check_all("R5");
   endtask

   task automatic t_rom32q_R6;
      do_write(3'd3, 3'd1, {8'd200, 8'd7, 8'd6, 8'd5}, 8'h00);
      m_bank[4] = wrapb(5, 6); m_bank[5] = wrapb(6, 6);
      m_bank[6] = wrapb(7, 6); m_bank[7] = wrapb(200, 6);
      check_all("R6");
   endtask

   task automatic t_raw_R7_R8;
      do_write(3'd4, 3'd2, 32'd37, 8'hFF);
      m_bank[2] = 8'd37; m_kind[2] = 8'hFF;
      do_write(3'd4, 3'd1, 32'd3, 8'h01);
      m_bank[1] = 8'd3; m_kind[1] = 8'h01;
      do_write(3'd4, 3'd0, 32'd9, 8'h80);
      m_bank[0] = 8'd9; m_kind[0] = 8'h80;
      do_write(3'd4, 3'd5, 32'd250, 8'h42);
      m_bank[5] = 8'd250; m_kind[5] = 8'h42;
      check_all("R7");
      check_win(2, 13'h0ABC, "R8 ram");
      check_win(1, 13'h0ABC, "R8 disk");
      check_win(0, 13'h0ABC, "R8 mapper");
      check_win(5, 13'h0ABC, "R8 unknown");
   endtask

   task automatic t_reserved_R10;
      do_write(3'd5, 3'd3, 32'h01010101, 8'hFF);
      do_write(3'd6, 3'd4, 32'h02020202, 8'h01);
      do_write(3'd7, 3'd6, 32'h03030303, 8'h80);
      check_all("R10");
   endtask

   task automatic t_zero_size_R11;
      rom_banks = 8'd0;
      do_write(3'd0, 3'd6, 32'd9, 8'h00);
      m_bank[6] = 8'd0; m_kind[6] = 8'h00;
      check_all("R11");
      rom_banks = 8'd6;
   endtask

   initial begin
      t_reset_R2;
      t_rom8_R3;
      t_timing_R9;
      t_rom16_R4;
      t_rom32_R5;
      t_rom32q_R6;
      t_raw_R7_R8;
      t_reserved_R10;
      t_zero_size_R11;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule